// File: doc/BRIEF.md
# DDR3 Command Decode Front End

This block sits on the device side of a DDR3-style command/address bus. On every rising clock edge it samples clock enable, chip select, the three active-low strobes (row strobe, column strobe, write enable), the bank bits and the address bus. From these it classifies the command and produces, one cycle later, a registered record of the command together with the fields that belong to it. The fields are the row address, the column address, the auto-precharge flag, single-bank or all-bank precharge, a four-beat burst-chop indication, the mode-register index and the mode-register op-code.

The block keeps a vector of open banks. It also keeps the stored burst setting taken from mode register 0. A power-state machine uses the open-bank vector to tell precharge power-down from active power-down when clock enable is registered low. The machine has four states. `PWR_ON` is normal operation. `PWR_PRE_PD` is power-down with all banks idle. `PWR_ACT_PD` is power-down with a row open. `PWR_SELF_REF` is self refresh. The transitions are:
- `PWR_ON` to `PWR_PRE_PD`: clock enable low, no bank open.
- `PWR_ON` to `PWR_ACT_PD`: clock enable low, some bank open.
- `PWR_ON` to `PWR_SELF_REF`: a refresh code with clock enable low and no bank open.
- Any other state back to `PWR_ON`: clock enable sampled high.

The self-refresh indicator drops as soon as clock enable rises, without waiting for a clock edge. A downstream command engine uses the outputs. The engine can trust that masked or gated cycles always appear as NOP.

Top module: `ddr3_cmd_front`

## Requirements
- R1: While cs_n is sampled high, the next cmd_o is NOP (code 0), whatever the other strobes are, and open_banks_o does not change.
- R2: Commands are decoded from {cs_n,ras_n,cas_n,we_n}, and cmd_o reports them one cycle after the sampling edge. The mapping is:
  - 0011 is ACTIVATE (cmd_o 1).
  - 0101 is READ (2).
  - 0100 is WRITE (3).
  - 0010 is PRECHARGE (4).
  - 0000 is LOAD MODE (5).
  - 0001 is REFRESH (6).
  - Any other code is NOP (0).
- R3: On ACTIVATE, row_o carries the full address bus and bank_o carries the bank bits. The bank's bit in open_banks_o is set. bank_o also reports the bank for READ, WRITE and PRECHARGE, and is 0 otherwise.
- R4: On READ and WRITE, col_o carries the address bus with bits 10 and 12 cleared, and auto_pre_o carries address bit 10. When bit 10 is high, the accessed bank's open bit is cleared at the same edge that reports the access.
- R5: On PRECHARGE, address bit 10 low clears only the addressed bank's open bit. Bit 10 high clears all open bits, and pre_all_o reports bit 10.
- R6: On LOAD MODE, mr_idx_o carries the bank bits [1:0] and opcode_o carries the address bus. The burst setting is changed only by a load to index 0, where op-code bits [1:0] select it:
  - 00 selects a fixed 8-beat burst.
  - 01 selects on-the-fly chop.
  - 10 selects a fixed 4-beat chop.
  - 11 leaves the setting unchanged.
- R7: chop4_o reports the burst length of a READ or WRITE. In on-the-fly mode, chop4_o is 1 when address bit 12 is low and 0 when it is high. In fixed modes, bit 12 is ignored: chop4_o is 0 for the 8-beat setting and 1 for the 4-beat setting.
- R8: Clock enable sampled low in state ON gives pwr_o 1 (precharge power-down) if no bank is open, or 2 (active power-down) otherwise. That cycle and every power-down cycle report NOP and leave the bank state unchanged.
- R9: From either power-down state, clock enable sampled high returns pwr_o to 0. The exit cycle reports NOP, and commands are decoded again from the following edge.
- R10: A REFRESH code with clock enable low, in state ON with all banks idle, gives pwr_o 3. sr_active_o is high while in self refresh with clock enable low. It falls as soon as clock enable rises, with no clock edge, and the next edge returns pwr_o to 0.
- R11: An active-low asynchronous reset gives the following state:
  - cmd_o is NOP.
  - open_banks_o is 0.
  - pwr_o is 0.
  - The burst setting is the fixed 8-beat burst.
  - All field outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank bits |
| addr | input | 14 | Address bus |
| cmd_o | output | 3 | Decoded command code |
| bank_o | output | 3 | Bank of the command |
| row_o | output | 14 | Row address for ACTIVATE |
| col_o | output | 14 | Column address for READ/WRITE |
| auto_pre_o | output | 1 | Auto-precharge flag |
| pre_all_o | output | 1 | All-bank precharge |
| chop4_o | output | 1 | Burst chopped to four beats |
| mr_idx_o | output | 2 | Mode register index |
| opcode_o | output | 14 | Mode register op-code |
| open_banks_o | output | 8 | Open-bank vector |
| pwr_o | output | 2 | Power state: 0 on, 1 precharge power-down, 2 active power-down, 3 self refresh |
| sr_active_o | output | 1 | Self refresh in progress |

## Verification
The bench builds the block with its default parameters:
- A 14-bit address.
- Eight banks.
- The auto-precharge select on bit 10.
- The chop select on bit 12.

With these values both reinterpreted address bits sit inside the bus, and the three bank bits reach every mode-register index as well as a spare high bit that must not block a load to index 0. Eight banks let random ACTIVATE and PRECHARGE traffic move the open vector between empty and non-empty often. Because of that, clock-enable drops reach both power-down states as well as self refresh. Frequent mode loads switch the burst setting under live READ and WRITE traffic.

// File: rtl/ddr3_cmd_pkg.sv
package ddr3_cmd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_LMR = 3'd5,
        CMD_REF = 3'd6
    } cmd_e;

    typedef enum logic [1:0] {
        PWR_ON       = 2'd0,
        PWR_PRE_PD   = 2'd1,
        PWR_ACT_PD   = 2'd2,
        PWR_SELF_REF = 2'd3
    } pwr_e;

    typedef enum logic [1:0] {
        BURST_FIX8 = 2'd0,
        BURST_OTF  = 2'd1,
        BURST_FIX4 = 2'd2
    } burst_e;

endpackage

// File: rtl/ddr3_cmd_classify.sv
module ddr3_cmd_classify
    import ddr3_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd_o
);

    logic [3:0] code;
    assign code = {cs_n, ras_n, cas_n, we_n};

    // Active-low command code table (R2)
    always_comb begin
        unique case (code)
            4'b0011: cmd_o = CMD_ACT;
            4'b0101: cmd_o = CMD_RD;
            4'b0100: cmd_o = CMD_WR;
            4'b0010: cmd_o = CMD_PRE;
            4'b0000: cmd_o = CMD_LMR;
            4'b0001: cmd_o = CMD_REF;
            default: cmd_o = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/ddr3_bank_tracker.sv
module ddr3_bank_tracker
    import ddr3_cmd_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int BA_W = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  cmd_e                 cmd_i,
    input  logic [BA_W-1:0]      bank_i,
    input  logic                 a10_i,
    output logic [NUM_BANKS-1:0] open_o
);

    logic [NUM_BANKS-1:0] open_q;
    logic [NUM_BANKS-1:0] open_d;
    logic [NUM_BANKS-1:0] bank_sel;

    assign bank_sel = NUM_BANKS'(1) << bank_i;

    always_comb begin
        open_d = open_q;
        unique case (cmd_i)
            CMD_ACT: open_d = open_q | bank_sel;
            CMD_RD,
            CMD_WR: begin
                if (a10_i) open_d = open_q & ~bank_sel;
            end
            CMD_PRE: begin
                if (a10_i) open_d = '0;
                else       open_d = open_q & ~bank_sel;
            end
            default: open_d = open_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) open_q <= '0;
        else        open_q <= open_d;
    end

    assign open_o = open_q;

    assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_ACT) |=> open_q[$past(bank_i)]);

    assert_autopre_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_i == CMD_RD || cmd_i == CMD_WR) && a10_i) |=> !open_q[$past(bank_i)]);

    assert_pre_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_PRE && a10_i) |=> (open_q == '0));

    assert_pre_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_PRE && !a10_i) |=> !open_q[$past(bank_i)]);

    assert_nop_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_NOP) |=> $stable(open_q));

endmodule

// File: rtl/ddr3_power_fsm.sv
module ddr3_power_fsm
    import ddr3_cmd_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke_i,
    input  logic                 ref_i,
    input  logic [NUM_BANKS-1:0] open_i,
    output pwr_e                 state_o,
    output logic                 accept_o,
    output logic                 sr_active_o
);

    pwr_e state_q;
    pwr_e state_d;
    logic all_idle;

    assign all_idle = (open_i == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_ON;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_ON: begin
                if (!cke_i) begin
                    if (ref_i && all_idle) state_d = PWR_SELF_REF;
                    else if (all_idle)     state_d = PWR_PRE_PD;
                    else                   state_d = PWR_ACT_PD;
                end
            end
            PWR_PRE_PD,
            PWR_ACT_PD,
            PWR_SELF_REF: begin
                if (cke_i) state_d = PWR_ON;
            end
            default: state_d = PWR_ON;
        endcase
    end

    always_comb begin
        accept_o    = 1'b0;
        sr_active_o = 1'b0;
        unique case (state_q)
            PWR_ON:       accept_o    = cke_i;
            PWR_SELF_REF: sr_active_o = !cke_i;
            default: begin
                accept_o    = 1'b0;
                sr_active_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

    assert_pre_pd_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_ON && !cke_i && !ref_i && all_idle) |=> (state_q == PWR_PRE_PD));

    assert_act_pd_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_ON && !cke_i && !all_idle) |=> (state_q == PWR_ACT_PD));

    assert_act_pd_rows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_ACT_PD) |-> !all_idle);

    assert_pd_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == PWR_PRE_PD || state_q == PWR_ACT_PD) && cke_i) |=> (state_q == PWR_ON));

    assert_sr_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_ON && !cke_i && ref_i && all_idle) |=> (state_q == PWR_SELF_REF));

endmodule

// File: rtl/ddr3_mode_store.sv
module ddr3_mode_store
    import ddr3_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [1:0] mr_i,
    input  logic [1:0] op_i,
    output burst_e     mode_o
);

    burst_e mode_q;
    logic   take;

    assign take = load_i && (mr_i == 2'd0) && (op_i != 2'b11);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    mode_q <= BURST_FIX8;
        else if (take) mode_q <= burst_e'(op_i);
    end

    assign mode_o = mode_q;

    assert_reserved_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && op_i == 2'b11) |=> $stable(mode_q));

    assert_other_mr_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && mr_i != 2'd0) |=> $stable(mode_q));

    assert_no_load_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i) |=> $stable(mode_q));

endmodule

// File: rtl/ddr3_cmd_front.sv
module ddr3_cmd_front
    import ddr3_cmd_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int NUM_BANKS = 8,
    parameter int AP_BIT    = 10,
    parameter int BC_BIT    = 12,
    localparam int BA_W     = $clog2(NUM_BANKS),
    localparam int MR_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic [ADDR_W-1:0]    addr,
    output logic [2:0]           cmd_o,
    output logic [BA_W-1:0]      bank_o,
    output logic [ADDR_W-1:0]    row_o,
    output logic [ADDR_W-1:0]    col_o,
    output logic                 auto_pre_o,
    output logic                 pre_all_o,
    output logic                 chop4_o,
    output logic [MR_W-1:0]      mr_idx_o,
    output logic [ADDR_W-1:0]    opcode_o,
    output logic [NUM_BANKS-1:0] open_banks_o,
    output logic [1:0]           pwr_o,
    output logic                 sr_active_o
);

    localparam logic [ADDR_W-1:0] COL_MASK =
        ~((ADDR_W'(1) << AP_BIT) | (ADDR_W'(1) << BC_BIT));

    cmd_e   raw_cmd;
    cmd_e   eff_cmd;
    pwr_e   pwr_state;
    burst_e burst_mode;
    logic   accept;
    logic   chop_now;
    logic   is_access;
    logic [NUM_BANKS-1:0] open_vec;

    cmd_e              cmd_q;
    logic [BA_W-1:0]   bank_q;
    logic [ADDR_W-1:0] row_q;
    logic [ADDR_W-1:0] col_q;
    logic              ap_q;
    logic              all_q;
    logic              chop_q;
    logic [MR_W-1:0]   mr_q;
    logic [ADDR_W-1:0] op_q;

    ddr3_cmd_classify u_classify (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd_o (raw_cmd)
    );

    ddr3_power_fsm #(.NUM_BANKS(NUM_BANKS)) u_power (
        .clk         (clk),
        .rst_n       (rst_n),
        .cke_i       (cke),
        .ref_i       (raw_cmd == CMD_REF),
        .open_i      (open_vec),
        .state_o     (pwr_state),
        .accept_o    (accept),
        .sr_active_o (sr_active_o)
    );

    assign eff_cmd   = accept ? raw_cmd : CMD_NOP;
    assign is_access = (eff_cmd == CMD_RD) || (eff_cmd == CMD_WR);

    ddr3_bank_tracker #(.NUM_BANKS(NUM_BANKS)) u_banks (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (eff_cmd),
        .bank_i (ba),
        .a10_i  (addr[AP_BIT]),
        .open_o (open_vec)
    );

    ddr3_mode_store u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (eff_cmd == CMD_LMR),
        .mr_i   (ba[MR_W-1:0]),
        .op_i   (addr[1:0]),
        .mode_o (burst_mode)
    );

    always_comb begin
        unique case (burst_mode)
            BURST_OTF:  chop_now = !addr[BC_BIT];
            BURST_FIX4: chop_now = 1'b1;
            default:    chop_now = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOP;
            bank_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
            ap_q   <= 1'b0;
            all_q  <= 1'b0;
            chop_q <= 1'b0;
            mr_q   <= '0;
            op_q   <= '0;
        end else begin
            cmd_q  <= eff_cmd;
            bank_q <= (eff_cmd == CMD_ACT || is_access || eff_cmd == CMD_PRE) ? ba : '0;
            row_q  <= (eff_cmd == CMD_ACT) ? addr : '0;
            col_q  <= is_access ? (addr & COL_MASK) : '0;
            ap_q   <= is_access && addr[AP_BIT];
            all_q  <= (eff_cmd == CMD_PRE) && addr[AP_BIT];
            chop_q <= is_access && chop_now;
            mr_q   <= (eff_cmd == CMD_LMR) ? ba[MR_W-1:0] : '0;
            op_q   <= (eff_cmd == CMD_LMR) ? addr : '0;
        end
    end

    assign cmd_o        = cmd_q;
    assign bank_o       = bank_q;
    assign row_o        = row_q;
    assign col_o        = col_q;
    assign auto_pre_o   = ap_q;
    assign pre_all_o    = all_q;
    assign chop4_o      = chop_q;
    assign mr_idx_o     = mr_q;
    assign opcode_o     = op_q;
    assign open_banks_o = open_vec;
    assign pwr_o        = pwr_state;

    assert_cs_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (cmd_q == CMD_NOP));

    assert_cke_low_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> (cmd_q == CMD_NOP));

    assert_fixed8_nochop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_access && burst_mode == BURST_FIX8) |=> !chop_q);

    assert_fixed4_chop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_access && burst_mode == BURST_FIX4) |=> chop_q);

endmodule

// File: tb/ddr3_cmd_front_tb.sv
`timescale 1ns/1ps
module ddr3_cmd_front_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [2:0]  ba = '0;
    logic [13:0] addr = '0;
    logic [2:0]  cmd_o;
    logic [2:0]  bank_o;
    logic [13:0] row_o, col_o, opcode_o;
    logic        auto_pre_o, pre_all_o, chop4_o, sr_active_o;
    logic [1:0]  mr_idx_o, pwr_o;
    logic [7:0]  open_banks_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model state
    logic [7:0] m_open = '0;
    int         m_mode = 0;
    int         m_pwr = 0;

    always #2 clk = ~clk;

    ddr3_cmd_front u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o),
        .bank_o(bank_o), .row_o(row_o), .col_o(col_o), .auto_pre_o(auto_pre_o),
        .pre_all_o(pre_all_o), .chop4_o(chop4_o), .mr_idx_o(mr_idx_o),
        .opcode_o(opcode_o), .open_banks_o(open_banks_o), .pwr_o(pwr_o),
        .sr_active_o(sr_active_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int decode(input logic [3:0] code);
        case (code)
            4'b0011: return 1;
            4'b0101: return 2;
            4'b0100: return 3;
            4'b0010: return 4;
            4'b0000: return 5;
            4'b0001: return 6;
            default: return 0;
        endcase
    endfunction

    // Drive one sample, advance one edge, compare every output to the model.
    task automatic apply(input logic k, input logic [3:0] code, input logic [2:0] b,
                         input logic [13:0] a);
        int raw, ec, npwr;
        logic [7:0] nopen;
        logic e_chop;
        @(negedge clk);
        cke = k; {cs_n, ras_n, cas_n, we_n} = code; ba = b; addr = a;
        raw = decode(code);
        ec = (m_pwr == 0 && k) ? raw : 0;
        nopen = m_open;
        case (ec)
            1: nopen[b] = 1'b1;
            2, 3: if (a[10]) nopen[b] = 1'b0;
            4: if (a[10]) nopen = '0; else nopen[b] = 1'b0;
            default: ;
        endcase
        e_chop = (m_mode == 1) ? !a[12] : (m_mode == 2);
        npwr = m_pwr;
        if (m_pwr == 0) begin
            if (!k) npwr = (raw == 6 && m_open == 0) ? 3 : (m_open == 0 ? 1 : 2);
        end else if (k) npwr = 0;
        @(posedge clk);
        #1;
        check("R2 cmd", cmd_o, ec);
        check("R3 bank", bank_o, (ec >= 1 && ec <= 4) ? b : 0);
        check("R3 row", row_o, (ec == 1) ? a : 0);
        check("R4 col", col_o, (ec == 2 || ec == 3) ? (a & 14'h2bff) : 0);
        check("R4 autopre", auto_pre_o, (ec == 2 || ec == 3) ? a[10] : 0);
        check("R5 preall", pre_all_o, (ec == 4) ? a[10] : 0);
        check("R7 chop", chop4_o, (ec == 2 || ec == 3) ? e_chop : 0);
        check("R6 mridx", mr_idx_o, (ec == 5) ? b[1:0] : 0);
        check("R6 opcode", opcode_o, (ec == 5) ? a : 0);
        check("R5 open", open_banks_o, nopen);
        check("R8 pwr", pwr_o, npwr);
        check("R10 sr", sr_active_o, (npwr == 3 && !k));
        m_open = nopen;
        m_pwr = npwr;
        if (ec == 5 && b[1:0] == 0 && a[1:0] != 2'b11) m_mode = a[1:0];
    endtask

    localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                           C_PRE = 4'b0010, C_LMR = 4'b0000, C_REF = 4'b0001,
                           C_NOP = 4'b0111;

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = C_NOP; cke = 1'b1;
        #1;
        m_open = '0; m_mode = 0; m_pwr = 0;
        check("R11 cmd", cmd_o, 0);
        check("R11 open", open_banks_o, 0);
        check("R11 pwr", pwr_o, 0);
        check("R11 row", row_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R1: chip select high masks an ACTIVATE code
        apply(1, 4'b1011, 3'd2, 14'h0111);
        check("R1 masked cmd", cmd_o, 0);
        check("R1 open unchanged", open_banks_o, 0);

        // R3: activate bank 3
        apply(1, C_ACT, 3'd3, 14'h1abc);
        check("R3 open bit", open_banks_o, 8'h08);
        // R2/R4: read without auto-precharge
        apply(1, C_RD, 3'd3, 14'h0123);
        check("R4 bank kept open", open_banks_o, 8'h08);
        // R6: on-the-fly chop via index 0
        apply(1, C_LMR, 3'd0, 14'h0001);
        apply(1, C_WR, 3'd3, 14'h0000);
        check("R7 otf a12 low", chop4_o, 1);
        apply(1, C_WR, 3'd3, 14'h1000);
        check("R7 otf a12 high", chop4_o, 0);
        apply(1, C_WR, 3'd3, 14'h0400);
        check("R4 autopre closes", open_banks_o, 8'h00);
        // R6: reserved code and other index keep setting
        apply(1, C_LMR, 3'd0, 14'h0003);
        apply(1, C_LMR, 3'd2, 14'h0002);
        apply(1, C_RD, 3'd1, 14'h0000);
        check("R6 setting kept otf", chop4_o, 1);
        apply(1, C_LMR, 3'd4, 14'h0002);
        apply(1, C_RD, 3'd1, 14'h1000);
        check("R7 fixed4 ignores a12", chop4_o, 1);
        apply(1, C_LMR, 3'd0, 14'h0000);
        apply(1, C_RD, 3'd1, 14'h0000);
        check("R7 fixed8 ignores a12", chop4_o, 0);
        // R5: single and all precharge
        apply(1, C_ACT, 3'd0, 14'h0005);
        apply(1, C_ACT, 3'd5, 14'h0006);
        apply(1, C_PRE, 3'd0, 14'h0000);
        check("R5 single close", open_banks_o, 8'h20);
        apply(1, C_PRE, 3'd7, 14'h0400);
        check("R5 all close", open_banks_o, 8'h00);
        // R8: precharge power-down, commands ignored inside
        apply(0, C_NOP, 3'd0, 14'h0);
        check("R8 pre pd", pwr_o, 1);
        apply(0, C_ACT, 3'd1, 14'h0);
        check("R8 masked in pd", open_banks_o, 0);
        // R9: exit; the exit sample is masked
        apply(1, C_ACT, 3'd1, 14'h0);
        check("R9 exit on", pwr_o, 0);
        check("R9 exit cmd nop", cmd_o, 0);
        // R8: active power-down
        apply(1, C_ACT, 3'd2, 14'h0);
        apply(0, C_NOP, 3'd0, 14'h0);
        check("R8 act pd", pwr_o, 2);
        apply(1, C_NOP, 3'd0, 14'h0);
        check("R9 act pd exit", pwr_o, 0);
        // R10: self refresh, asynchronous exit indicator
        apply(1, C_PRE, 3'd0, 14'h0400);
        apply(0, C_REF, 3'd0, 14'h0);
        check("R10 sr state", pwr_o, 3);
        check("R10 sr active", sr_active_o, 1);
        @(negedge clk);
        cke = 1'b1;
        #0.5;
        check("R10 sr drops without edge", sr_active_o, 0);
        apply(1, C_NOP, 3'd0, 14'h0);
        check("R10 sr exit", pwr_o, 0);

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic k;
            logic [3:0] code;
            int sel;
            k = ($urandom % 16) != 0;
            sel = $urandom % 10;
            case (sel)
                0, 1: code = C_ACT;
                2: code = C_RD;
                3: code = C_WR;
                4: code = C_PRE;
                5: code = C_LMR;
                6: code = C_REF;
                7: code = {1'b1, 3'($urandom)};
                8: code = 4'($urandom);
                default: code = C_NOP;
            endcase
            apply(k, code, 3'($urandom), 14'($urandom));
        end

        // R11: reset mid-run clears state
        apply(1, C_ACT, 3'd6, 14'h0);
        do_reset();
        apply(1, C_RD, 3'd6, 14'h0);
        check("R11 burst setting fixed8", chop4_o, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule